// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer and Event Counter

This block is an 8-bit up-counter that has a reload register, a control register and a sticky overflow flag. The control register selects one of three counting sources. In timer mode the counter counts a divided-down copy of the system clock. In event mode it counts edges on an external pin. In pulse-width mode it counts the divided clock only while the external pin sits at its active level. When the counter steps past 8'hFF it takes the reload value and keeps counting. It also raises an overflow pulse, which the interrupt-enable input can gate.

Software reaches the block through a simple register port. A write takes one cycle and a read is combinational. The external pin is synchronized inside the block, so it may come from an asynchronous source.

Top module: `evt_timer8`

## Requirements
- R1: After reset the control, reload and counter registers read 0, the flag reads 0 and `irq_o` is 0.
- R2: Register map. Address 0 is control, with bits [7:6] mode, bit 4 run, bit 3 polarity and bits [2:0] divider select; bit 5 always reads 0. Address 1 is reload. Address 2 is the counter and is read-only, so writes to it are ignored. Address 3 is status, with bit 0 as the overflow flag and all other bits reading 0.
- R3: The counter holds its value when the run bit is 0, or when the mode is 2'b00.
- R4: Mode 2'b10 (timer) increments the counter once every 2^S clocks, where S is the divider select. After N clock edges with run set, the counter has advanced by floor(N / 2^S).
- R5: Mode 2'b01 (event) increments once for each edge of the synchronized pin: the rising edge when polarity is 0, the falling edge when polarity is 1. The divider select has no effect in this mode.
- R6: Mode 2'b11 (pulse width) increments on the divided clock only while the synchronized pin is at its active level: high when polarity is 0, low when polarity is 1. With S=0, a pulse lasting L clocks yields a count of L.
- R7: In pulse-width mode, the pin leaving its active level clears the run bit by hardware.
- R8: An increment at 8'hFF loads the reload value instead, and counting continues.
- R9: Each wrap produces a one-cycle `irq_o` pulse when `irq_en_i` is 1, and no pulse when it is 0. The pulse appears in the cycle in which the counter already shows the reload value.
- R10: Each wrap sets the flag whatever the value of `irq_en_i`. Writing 1 to bit 0 of status clears the flag, and writing 0 leaves it unchanged.
- R11: A write to reload while run is 0 also loads the counter. While run is 1, the same write changes only the reload register.
- R12: Clearing the run bit restarts the clock divider from zero, so a later run starts a full 2^S period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| ext_i | input | 1 | External event / gate pin, asynchronous |
| irq_en_i | input | 1 | Overflow interrupt enable |
| irq_o | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The assertions assume that the counter never gets an increment and a load in the same cycle. They also assume that a write to reload while stopped is the only source of a load, and that `irq_en_i` changes only between clock edges. The stimulus drives every input on the falling clock edge. It changes mode, polarity and divider only with run cleared, or in the same write that sets run. It gives the pin level changes several clocks apart, so that every edge passes cleanly through the synchronizer.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RELD = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int MODE_LSB = 6;
  localparam int RUN_BIT  = 4;
  localparam int POL_BIT  = 3;
  localparam int SEL_W    = 3;
  localparam logic [DW-1:0] CTRL_MASK = 8'hDF;
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int ACC_W = (1 << SEL_W) - 1;
  localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   span;
  logic [ACC_W-1:0] mask;

  assign span   = (ONE << div_sel_i) - ONE;
  assign mask   = span[ACC_W-1:0];
  assign tick_o = run_i && ((acc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (!run_i) acc_q <= '0;
    else             acc_q <= acc_q + ACC_W'(1);
  end

  p_div_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> acc_q == '0);
endmodule

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic pol_i,
  output logic act_o,
  output logic edge_o,
  output logic release_o
);
  logic [STAGES-1:0] chain_q;
  logic              lvl, lvl_d_q, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= ext_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign lvl = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d_q <= 1'b0;
    else         lvl_d_q <= lvl;
  end

  assign rise      = lvl & ~lvl_d_q;
  assign fall      = ~lvl & lvl_d_q;
  assign act_o     = lvl ^ pol_i;
  assign edge_o    = pol_i ? fall : rise;
  assign release_o = pol_i ? rise : fall;

  p_edge_lands_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |-> act_o);
endmodule

// File: rtl/evt_count8.sv
module evt_count8 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = inc_i && (cnt_q == {W{1'b1}});
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wrap_o) cnt_q <= reload_i;
    else if (inc_i)  cnt_q <= cnt_q + W'(1);
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_q));
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && cnt_q != {W{1'b1}}) |=> cnt_q == $past(cnt_q) + W'(1));
  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !load_i) |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          ext_i,
  input  logic          irq_en_i,
  output logic          irq_o
);
  logic [DW-1:0] ctrl_q, reld_q, cnt;
  logic          flag_q, irq_q;
  logic          run, pol, tick, act, edge_hit, release_hit, inc, wrap, reld_load;
  logic          wr_ctrl, wr_reld, wr_stat, auto_stop;
  mode_e         mode;

  assign mode = mode_e'(ctrl_q[MODE_LSB+1:MODE_LSB]);
  assign run  = ctrl_q[RUN_BIT];
  assign pol  = ctrl_q[POL_BIT];

  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_reld = wr_en_i && (wr_addr_i == A_RELD);
  assign wr_stat = wr_en_i && (wr_addr_i == A_STAT);

  evt_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .div_sel_i (ctrl_q[SEL_W-1:0]),
    .tick_o    (tick)
  );

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_i     (ext_i),
    .pol_i     (pol),
    .act_o     (act),
    .edge_o    (edge_hit),
    .release_o (release_hit)
  );

  always_comb begin
    unique case (mode)
      MODE_TIMER: inc = run && tick;
      MODE_EVENT: inc = run && edge_hit;
      MODE_PULSE: inc = run && tick && act;
      default:    inc = 1'b0;
    endcase
  end

  assign reld_load = wr_reld && !run;
  assign auto_stop = run && (mode == MODE_PULSE) && release_hit;

  evt_count8 #(.W(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc && !reld_load),
    .load_i     (reld_load),
    .load_val_i (wr_data_i),
    .reload_i   (reld_q),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      reld_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl)        ctrl_q <= wr_data_i & CTRL_MASK;
      else if (auto_stop) ctrl_q[RUN_BIT] <= 1'b0;
      if (wr_reld)        reld_q <= wr_data_i;
      if (wrap)                       flag_q <= 1'b1;
      else if (wr_stat && wr_data_i[0]) flag_q <= 1'b0;
      irq_q <= wrap && irq_en_i;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_RELD:  rd_data_o = reld_q;
      A_CNT:   rd_data_o = cnt;
      default: rd_data_o = {{(DW-1){1'b0}}, flag_q};
    endcase
  end

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
  p_irq_shows_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt == $past(reld_q));
  p_flag_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> flag_q);
  p_pw_autostop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_stop && !wr_ctrl) |=> !ctrl_q[RUN_BIT]);
  p_no_pw_stop_elsewhere_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wr_ctrl && mode != MODE_PULSE) |=> ctrl_q[RUN_BIT]);
endmodule

// File: tb/evt_timer8_tb_top.sv
`timescale 1ns/1ps
module evt_timer8_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [1:0] wr_addr_i;
  logic [7:0] wr_data_i;
  logic [1:0] rd_addr_i;
  logic [7:0] rd_data_o;
  logic       ext_i;
  logic       irq_en_i;
  logic       irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  evt_timer8 dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ext_i     (ext_i),
    .irq_en_i  (irq_en_i),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic chk_rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic halt_and_load(input logic [7:0] v);
    wr(2'd0, 8'h00);
    wr(2'd1, v);
  endtask

  task automatic t_reset;
    chk_rd("R1 ctrl", 2'd0, 8'h00);
    chk_rd("R1 reload", 2'd1, 8'h00);
    chk_rd("R1 count", 2'd2, 8'h00);
    chk_rd("R1 flag", 2'd3, 8'h00);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_regmap;
    wr(2'd0, 8'h2F);
    chk_rd("R2 ctrl bit5 reads 0", 2'd0, 8'h0F);
    halt_and_load(8'h21);
    wr(2'd2, 8'hAA);
    chk_rd("R2 count write ignored", 2'd2, 8'h21);
    chk_rd("R2 reload readback", 2'd1, 8'h21);
  endtask

  task automatic t_hold;
    halt_and_load(8'h33);
    chk_rd("R11 stopped reload loads count", 2'd2, 8'h33);
    wr(2'd0, 8'h10);
    step(6);
    chk_rd("R3 mode off holds", 2'd2, 8'h33);
    wr(2'd0, 8'h80);
    step(6);
    chk_rd("R3 run clear holds", 2'd2, 8'h33);
  endtask

  task automatic t_timer;
    halt_and_load(8'h00);
    wr(2'd0, 8'h90);
    step(10);
    chk_rd("R4 div1 count", 2'd2, 8'd10);
    halt_and_load(8'h00);
    wr(2'd0, 8'h93);
    step(20);
    chk_rd("R4 div8 count", 2'd2, 8'd2);
    step(4);
    chk_rd("R4 div8 count 24", 2'd2, 8'd3);
  endtask

  task automatic t_div_restart;
    halt_and_load(8'h00);
    wr(2'd0, 8'h92);
    step(2);
    chk_rd("R12 before stop", 2'd2, 8'd0);
    wr(2'd0, 8'h82);
    wr(2'd0, 8'h92);
    step(3);
    chk_rd("R12 divider restarted", 2'd2, 8'd0);
    step(1);
    chk_rd("R12 first tick full period", 2'd2, 8'd1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_running_reload;
    halt_and_load(8'h00);
    wr(2'd0, 8'h97);
    step(3);
    wr(2'd1, 8'h55);
    chk_rd("R11 running count untouched", 2'd2, 8'h00);
    chk_rd("R11 running reload stored", 2'd1, 8'h55);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_wrap_irq;
    logic [7:0] v;
    halt_and_load(8'hFD);
    wr(2'd3, 8'h01);
    irq_en_i = 1'b1;
    wr(2'd0, 8'h90);
    step(2);
    chk_rd("R8 at top", 2'd2, 8'hFF);
    chk("R9 no early irq", {7'd0, irq_o}, 8'h00);
    step(1);
    chk("R9 irq pulse", {7'd0, irq_o}, 8'h01);
    chk_rd("R8 reloaded", 2'd2, 8'hFD);
    chk_rd("R10 flag set", 2'd3, 8'h01);
    step(1);
    chk("R9 irq one cycle", {7'd0, irq_o}, 8'h00);
    chk_rd("R8 continues", 2'd2, 8'hFE);
    halt_and_load(8'hFE);
    wr(2'd3, 8'h01);
    chk_rd("R10 flag cleared", 2'd3, 8'h00);
    irq_en_i = 1'b0;
    wr(2'd0, 8'h90);
    step(1);
    v = {7'd0, irq_o};
    step(1);
    chk("R9 gated irq", v | {7'd0, irq_o}, 8'h00);
    chk_rd("R8 wrap gated", 2'd2, 8'hFE);
    wr(2'd0, 8'h00);
    chk_rd("R10 flag set when gated", 2'd3, 8'h01);
    wr(2'd3, 8'h00);
    chk_rd("R10 write 0 keeps flag", 2'd3, 8'h01);
    wr(2'd3, 8'h01);
    chk_rd("R10 write 1 clears", 2'd3, 8'h00);
  endtask

  task automatic pulse(input int hi, input int lo);
    ext_i = ~ext_i; step(hi);
    ext_i = ~ext_i; step(lo);
  endtask

  task automatic t_event;
    ext_i = 1'b0;
    halt_and_load(8'h00);
    wr(2'd0, 8'h57);
    for (int i = 0; i < 5; i++) pulse(3, 3);
    step(4);
    chk_rd("R5 rising edges, divider ignored", 2'd2, 8'd5);
    halt_and_load(8'h00);
    wr(2'd0, 8'h5F);
    for (int i = 0; i < 3; i++) pulse(3, 3);
    step(4);
    chk_rd("R5 falling edges", 2'd2, 8'd3);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_pulse;
    ext_i = 1'b0;
    halt_and_load(8'h00);
    wr(2'd0, 8'hD0);
    step(3);
    chk_rd("R6 idle no count", 2'd2, 8'd0);
    chk_rd("R7 still running", 2'd0, 8'hD0);
    ext_i = 1'b1; step(10);
    ext_i = 1'b0; step(5);
    chk_rd("R6 high pulse width", 2'd2, 8'd10);
    chk_rd("R7 run cleared", 2'd0, 8'hC0);
    ext_i = 1'b1;
    wr(2'd1, 8'h00);
    step(3);
    wr(2'd0, 8'hD8);
    step(2);
    chk_rd("R6 low-active idle", 2'd2, 8'd0);
    ext_i = 1'b0; step(6);
    ext_i = 1'b1; step(5);
    chk_rd("R6 low pulse width", 2'd2, 8'd6);
    chk_rd("R7 run cleared low", 2'd0, 8'hC8);
    ext_i = 1'b0;
    step(4);
  endtask

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    rd_addr_i = '0; ext_i = 1'b0; irq_en_i = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_hold();
    t_timer();
    t_div_restart();
    t_running_reload();
    t_wrap_irq();
    t_event();
    t_pulse();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule